// File: doc/BRIEF.md
# Injected Channel Conversion Sequencer

This block decides which input channel a sigma-delta decimation filter converts next, and when, for a group of injected channels. A mask register holds the selected channels. A trigger is either a software start strobe or, in synchronous-launch mode, the start pulse of a master filter. When a trigger is accepted, the block points the datapath at a channel and pulses a start line. It then waits for the datapath's done handshake.

In single mode each trigger converts one channel, and the pointer then moves round-robin to the next selected channel. In scan mode each trigger walks every selected channel in ascending order, beginning with the lowest.

When the last conversion of a trigger finishes, the block:
- drops its in-progress flag;
- raises an end-of-conversion flag, which a result read clears;
- raises an overrun flag if the previous result was never read;
- issues a one-cycle DMA request when DMA is enabled.

The mode bits can be written only while the filter is disabled. Disabling the filter aborts any conversion and clears the status flags.

The controller has three states:
- `S_IDLE`: waiting for a trigger.
- `S_LAUNCH`: one cycle with the start pulse high.
- `S_WAIT`: waiting for the done handshake.

The transitions are:
- IDLE→LAUNCH: a trigger is accepted.
- LAUNCH→WAIT: always, after the one launch cycle.
- WAIT→LAUNCH: done arrives in scan mode and a higher selected channel remains.
- WAIT→IDLE: the final done arrives.
- Any state→IDLE: enable goes low.

Top module: `inj_seq_top`

## Requirements
- R1: After reset, `busy`, `conv_start`, `eoc`, `ovr` and `dma_req` are 0 and `ch_idx` is 0.
- R2: In single mode (`cfg_scan`=0), each trigger converts exactly one channel, the one the pointer holds. On completion the pointer moves to the next higher selected channel, wrapping from the highest selected channel to the lowest.
- R3: In scan mode (`cfg_scan`=1), each trigger converts every selected channel in ascending index order, always starting from the lowest selected channel.
- R4: A mask write (`mask_wr`=1) in single mode sets the pointer to the lowest selected channel of the new mask.
- R5: An accepted start strobe sampled at edge N gives `conv_start`=1 and `busy`=1 after edge N. `conv_start` lasts one cycle. `busy` stays 1 until the final completion.
- R6: A software start or master start that arrives while `busy`=1 has no effect.
- R7: With `cfg_sync`=1, `sw_start` is ignored and `master_start` launches the conversion.
- R8: With an all-zero mask, no trigger starts a conversion and `busy` stays 0. A start that coincides with a mask write is also dropped.
- R9: A configuration write (`cfg_wr`=1) while `en`=1 leaves scan, sync and DMA settings unchanged.
- R10: When `en` is 0 at an edge, `busy`, `eoc`, `ovr` and `dma_req` are 0 after it, and `conv_done` has no effect.
- R11: On the final completion of a trigger, `busy` falls, `eoc` rises, and `dma_req` is 1 for exactly one cycle if the DMA setting is 1 and stays 0 otherwise.
- R12: `rd_ack`=1 clears `eoc`. A final completion while `eoc`=1 and `rd_ack`=0 sets `ovr`, which stays set until disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Filter enable |
| cfg_wr | input | 1 | Write strobe for mode settings |
| cfg_scan | input | 1 | Scan mode value (1 = whole group per trigger) |
| cfg_sync | input | 1 | Synchronous-launch value |
| cfg_dma | input | 1 | DMA-enable value |
| mask_wr | input | 1 | Channel mask write strobe |
| mask_in | input | NUM_CH | New channel mask, bit i selects channel i |
| sw_start | input | 1 | Software start strobe |
| master_start | input | 1 | Start pulse from the master filter |
| conv_done | input | 1 | Datapath conversion finished |
| rd_ack | input | 1 | Result has been read |
| ch_idx | output | $clog2(NUM_CH) | Channel being converted |
| conv_start | output | 1 | One-cycle start pulse to datapath |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End of conversion flag |
| ovr | output | 1 | Overrun flag |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The bench builds the block with the default of eight channels. With eight channels, the scan walks can include both mask ends (channel 0 and channel 7), a fully set mask and sparse masks with gaps. Single-mode wrap-around from the highest selected channel back to the lowest can then be observed within a few triggers. At this width a full eight-conversion scan stays short enough to run next to the directed cases on abort, lockout and overrun.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_WAIT   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic scan;
        logic sync;
        logic dma;
    } seq_cfg_t;

endpackage

// File: rtl/inj_cfg_regs.sv
module inj_cfg_regs
    import inj_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     cfg_wr,
    input  logic     scan_in,
    input  logic     sync_in,
    input  logic     dma_in,
    output seq_cfg_t cfg
);

    // Mode bits are writable only while the filter is disabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr && !en) begin
            cfg.scan <= scan_in;
            cfg.sync <= sync_in;
            cfg.dma  <= dma_in;
        end
    end

endmodule

// File: rtl/inj_chan_ptr.sv
module inj_chan_ptr #(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_mode,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] mask_in,
    input  logic              load_first,
    input  logic              align,
    input  logic              step_up,
    input  logic              step_wrap,
    output logic [IDX_W-1:0]  ptr,
    output logic [NUM_CH-1:0] mask_q,
    output logic              more_above
);

    // Lowest selected index at or above 'from'; MSB flags a hit.
    function automatic logic [IDX_W:0] seek(input logic [NUM_CH-1:0] m, input int from);
        logic [IDX_W:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i] && i >= from) r = {1'b1, IDX_W'(i)};
        end
        return r;
    endfunction

    logic [IDX_W:0] above_q;
    logic [IDX_W:0] lowest_q;
    logic [IDX_W:0] lowest_new;
    logic [IDX_W-1:0] wrap_next;

    always_comb begin
        above_q    = seek(mask_q, int'(ptr) + 1);
        lowest_q   = seek(mask_q, 0);
        lowest_new = seek(mask_in, 0);
        more_above = above_q[IDX_W];
        wrap_next  = above_q[IDX_W] ? above_q[IDX_W-1:0] : lowest_q[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (mask_wr && !scan_mode) begin
            ptr <= lowest_new[IDX_W-1:0];
        end else if (load_first) begin
            ptr <= lowest_q[IDX_W-1:0];
        end else if (align) begin
            ptr <= mask_q[ptr] ? ptr : wrap_next;
        end else if (step_up) begin
            ptr <= above_q[IDX_W-1:0];
        end else if (step_wrap) begin
            ptr <= wrap_next;
        end
    end

endmodule

// File: rtl/inj_status.sv
module inj_status (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic last_done,
    input  logic rd_ack,
    input  logic dma_en,
    output logic eoc,
    output logic ovr,
    output logic dma_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc     <= 1'b0;
            ovr     <= 1'b0;
            dma_req <= 1'b0;
        end else if (!en) begin
            eoc     <= 1'b0;
            ovr     <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            dma_req <= last_done && dma_en;
            if (last_done) begin
                eoc <= 1'b1;
                if (eoc && !rd_ack) ovr <= 1'b1;
            end else if (rd_ack) begin
                eoc <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/inj_seq_top.sv
module inj_seq_top
    import inj_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_wr,
    input  logic              cfg_scan,
    input  logic              cfg_sync,
    input  logic              cfg_dma,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] mask_in,
    input  logic              sw_start,
    input  logic              master_start,
    input  logic              conv_done,
    input  logic              rd_ack,
    output logic [IDX_W-1:0]  ch_idx,
    output logic              conv_start,
    output logic              busy,
    output logic              eoc,
    output logic              ovr,
    output logic              dma_req
);

    seq_cfg_t          cfg;
    seq_state_e        state_q, state_d;
    logic [NUM_CH-1:0] mask_q;
    logic              more_above;
    logic              trig, done_ok, last_done;
    logic              load_first, align, step_up, step_wrap;

    inj_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cfg_wr  (cfg_wr),
        .scan_in (cfg_scan),
        .sync_in (cfg_sync),
        .dma_in  (cfg_dma),
        .cfg     (cfg)
    );

    inj_chan_ptr #(.NUM_CH(NUM_CH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_mode  (cfg.scan),
        .mask_wr    (mask_wr),
        .mask_in    (mask_in),
        .load_first (load_first),
        .align      (align),
        .step_up    (step_up),
        .step_wrap  (step_wrap),
        .ptr        (ch_idx),
        .mask_q     (mask_q),
        .more_above (more_above)
    );

    inj_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .last_done (last_done),
        .rd_ack    (rd_ack),
        .dma_en    (cfg.dma),
        .eoc       (eoc),
        .ovr       (ovr),
        .dma_req   (dma_req)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs.
    always_comb begin
        trig       = en && !mask_wr && (|mask_q) && (state_q == S_IDLE)
                     && (cfg.sync ? master_start : sw_start);
        done_ok    = en && (state_q == S_WAIT) && conv_done;
        last_done  = done_ok && !(cfg.scan && more_above);
        load_first = trig && cfg.scan;
        align      = trig && !cfg.scan;
        step_up    = done_ok && cfg.scan && more_above;
        step_wrap  = done_ok && !cfg.scan;
        conv_start = (state_q == S_LAUNCH);
        busy       = (state_q != S_IDLE);
        state_d    = state_q;
        unique case (state_q)
            S_IDLE:   if (trig) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_WAIT;
            S_WAIT:   if (done_ok) state_d = last_done ? S_IDLE : S_LAUNCH;
            default:  state_d = S_IDLE;
        endcase
        if (!en) state_d = S_IDLE;
    end

endmodule

// File: rtl/inj_seq_checker.sv
module inj_seq_checker #(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              busy,
    input logic              conv_start,
    input logic              eoc,
    input logic              ovr,
    input logic              dma_req,
    input logic [IDX_W-1:0]  ch_idx,
    input logic [NUM_CH-1:0] mask_q
);

    // R2 / R8: a launch always addresses a selected channel.
    p_sel_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> mask_q[ch_idx]);

    // R5: the in-progress flag rises together with the launch pulse.
    p_busy_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> conv_start);

    // R5: the launch pulse lasts a single cycle.
    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R10: disable clears activity and status.
    p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !eoc && !ovr && !dma_req));

    // R11: DMA request is one cycle wide and comes with the end flag.
    p_dma_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);
    p_dma_eoc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (eoc && !busy));

    // R12: overrun only exists alongside an unread result.
    p_ovr_eoc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> eoc);

endmodule

bind inj_seq_top inj_seq_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .busy       (busy),
    .conv_start (conv_start),
    .eoc        (eoc),
    .ovr        (ovr),
    .dma_req    (dma_req),
    .ch_idx     (ch_idx),
    .mask_q     (mask_q)
);

// File: tb/inj_seq_top_tb_top.sv
module inj_seq_top_tb_top;

    localparam int CLK_P  = 10;
    localparam int NUM_CH = 8;
    localparam int IDX_W  = $clog2(NUM_CH);

    typedef struct packed {
        logic [7:0]  mask;
        logic        scan;
        logic [3:0]  cnt;
        logic [23:0] seq;   // channel k of the walk in bits [3k+2:3k]
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'hA4, 1'b1, 4'd3, {15'd0, 3'd7, 3'd5, 3'd2}},
        '{8'h01, 1'b1, 4'd1, {21'd0, 3'd0}},
        '{8'h80, 1'b1, 4'd1, {21'd0, 3'd7}},
        '{8'hFF, 1'b1, 4'd8, {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}},
        '{8'h48, 1'b0, 4'd1, {21'd0, 3'd3}},
        '{8'h81, 1'b1, 4'd2, {18'd0, 3'd7, 3'd0}}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, cfg_wr = 1'b0, cfg_scan = 1'b0, cfg_sync = 1'b0, cfg_dma = 1'b0;
    logic mask_wr = 1'b0;
    logic [NUM_CH-1:0] mask_in = '0;
    logic sw_start = 1'b0, master_start = 1'b0, conv_done = 1'b0, rd_ack = 1'b0;
    logic [IDX_W-1:0] ch_idx;
    logic conv_start, busy, eoc, ovr, dma_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    inj_seq_top #(.NUM_CH(NUM_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .cfg_scan(cfg_scan),
        .cfg_sync(cfg_sync), .cfg_dma(cfg_dma), .mask_wr(mask_wr), .mask_in(mask_in),
        .sw_start(sw_start), .master_start(master_start), .conv_done(conv_done),
        .rd_ack(rd_ack), .ch_idx(ch_idx), .conv_start(conv_start), .busy(busy),
        .eoc(eoc), .ovr(ovr), .dma_req(dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic configure(input logic s, input logic y, input logic d);
        @(negedge clk); en = 1'b0; cfg_wr = 1'b1; cfg_scan = s; cfg_sync = y; cfg_dma = d;
        @(negedge clk); cfg_wr = 1'b0; en = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_mask(input logic [NUM_CH-1:0] m);
        @(negedge clk); mask_in = m; mask_wr = 1'b1;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic trigger_sw();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    // Entered at the negedge where the launch cycle is expected.
    task automatic do_conv(input int exp_ch, input logic last, input string req);
        chk("R5 conv_start", 32'(conv_start), 32'd1);
        chk("R5 busy", 32'(busy), 32'd1);
        chk(req, 32'(ch_idx), 32'(exp_ch));
        @(negedge clk);
        chk("R5 pulse width", 32'(conv_start), 32'd0);
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        if (last) begin
            chk("R11 busy falls", 32'(busy), 32'd0);
            chk("R11 eoc set", 32'(eoc), 32'd1);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 conv_start", 32'(conv_start), 32'd0);
        chk("R1 eoc", 32'(eoc), 32'd0);
        chk("R1 ovr", 32'(ovr), 32'd0);
        chk("R1 dma_req", 32'(dma_req), 32'd0);
        chk("R1 ch_idx", 32'(ch_idx), 32'd0);

        // Table: scan walks (R3) and single first channel (R2/R4)
        for (int v = 0; v < 6; v++) begin
            configure(VECS[v].scan, 1'b0, 1'b1);
            write_mask(VECS[v].mask);
            trigger_sw();
            for (int k = 0; k < int'(VECS[v].cnt); k++) begin
                do_conv(int'(VECS[v].seq[3*k +: 3]), (k == int'(VECS[v].cnt) - 1),
                        VECS[v].scan ? "R3 scan order" : "R2 single channel");
            end
            chk("R11 dma pulse", 32'(dma_req), 32'd1);
        end

        // R2 round robin, R11 dma width, R12 read and overrun
        configure(1'b0, 1'b0, 1'b1);
        write_mask(8'h49);
        trigger_sw(); do_conv(0, 1'b1, "R2 first");
        chk("R11 dma set", 32'(dma_req), 32'd1);
        @(negedge clk);
        chk("R11 dma one cycle", 32'(dma_req), 32'd0);
        pulse_rd();
        chk("R12 read clears eoc", 32'(eoc), 32'd0);
        trigger_sw(); do_conv(3, 1'b1, "R2 advance");
        chk("R12 no overrun yet", 32'(ovr), 32'd0);
        trigger_sw(); do_conv(6, 1'b1, "R2 advance");
        chk("R12 overrun", 32'(ovr), 32'd1);

        // R4 mask write resets pointer (would be 0 anyway by wrap: use mid-walk)
        trigger_sw(); do_conv(0, 1'b1, "R2 wrap");
        write_mask(8'h49);
        trigger_sw(); do_conv(0, 1'b1, "R4 pointer reset");
        trigger_sw(); do_conv(3, 1'b1, "R2 advance after reset");

        // R6 start while busy ignored
        trigger_sw();
        chk("R6 launch", 32'(ch_idx), 32'd6);
        sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        chk("R6 idle after done", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R6 no relaunch", 32'(busy), 32'd0);
        chk("R6 no start", 32'(conv_start), 32'd0);

        // R7 sync mode
        configure(1'b0, 1'b1, 1'b0);
        write_mask(8'h02);
        trigger_sw();
        chk("R7 sw ignored", 32'(busy), 32'd0);
        @(negedge clk); master_start = 1'b1;
        @(negedge clk); master_start = 1'b0;
        do_conv(1, 1'b1, "R7 master launch");
        chk("R11 no dma when off", 32'(dma_req), 32'd0);

        // R8 empty mask
        configure(1'b0, 1'b0, 1'b1);
        write_mask(8'h00);
        trigger_sw();
        chk("R8 no busy", 32'(busy), 32'd0);
        chk("R8 no start", 32'(conv_start), 32'd0);

        // R9 config write while enabled ignored (stays single)
        @(negedge clk); cfg_wr = 1'b1; cfg_scan = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        write_mask(8'h06);
        trigger_sw(); do_conv(1, 1'b1, "R9 still single");

        // R10 disable mid conversion
        trigger_sw();
        chk("R10 launch", 32'(ch_idx), 32'd2);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R10 busy cleared", 32'(busy), 32'd0);
        chk("R10 eoc cleared", 32'(eoc), 32'd0);
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        chk("R10 done ignored", 32'(eoc), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule